// File: doc/BRIEF.md
# Strap-Addressed Serial Configuration Write Port

This block is the write-only slave end of a two-wire serial bus, used to load a small bank of 8-bit configuration registers from a host. The clock and data lines are sampled on the local system clock. Bus start and stop conditions are recognised from the data line moving while the clock line is high. The first byte after a start is compared with a 7-bit device address that comes from strap inputs.

Once the address matches for a write, the next byte sets an internal 8-bit pointer. Every byte after that is stored at the pointer, and the pointer then steps by one. A host can therefore fill consecutive registers in one burst. The slave acknowledges by asserting an open-drain enable that pulls the data line low during the ninth clock of each accepted byte.

The register contents are always visible on a flat parallel bus. Reads, clock stretching, 10-bit addressing and general call are not supported.

Top module: `cfgw_wr_slave`

## Requirements
- R1: After reset every register reads zero on `regs_o` and `sda_oe_o` is low.
- R2: When a byte after START has its upper seven bits (first sent first) equal to `dev_addr_i` and its last bit 0, `sda_oe_o` is high during the ninth SCL pulse of that byte.
- R3: When the address differs or the last bit is 1, that byte and all later bytes get no acknowledge, and no register changes until the next START.
- R4: The byte after an accepted address is acknowledged and loads the write pointer.
- R5: Each later byte is acknowledged and stored, first bit as bit 7, into the register whose index equals the pointer. Register k occupies `regs_o[8k+7:8k]`.
- R6: The pointer increases by one after each stored byte, and wraps from 255 to 0.
- R7: A byte addressed with a pointer of NUM_REGS or more is acknowledged but changes no register.
- R8: A STOP returns the slave to idle, and bytes sent afterwards without a START get no acknowledge.
- R9: A START that arrives part-way through a byte abandons that byte and begins a new address reception.
- R10: `sda_oe_o` rises only on the clock after a detected SCL falling edge, and drops on the clock after an SCL falling edge, a START or a STOP.

Parameters: `NUM_REGS` (default 8) and `SYNC_STAGES` (default 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the pin |
| sda_i | input | 1 | Serial data line as seen on the pin (wired bus level) |
| dev_addr_i | input | 7 | Strapped device address |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls the data line low |
| regs_o | output | 8*NUM_REGS | Register contents, register 0 in the low byte |

## Verification
Two events land in the same clock cycle: storing a data byte and stepping the pointer. The bench provokes this by starting bursts at every pointer value in the bank, and also at 6 and at 254. Bursts from 6 run past the end of the bank. Bursts from 254 wrap through 255 to 0. The bench checks that each byte lands exactly one register above the previous one, that out-of-range bytes are still acknowledged but dropped, and that a byte sent after the wrap lands in register 0. In a second case, a START arrives in the middle of a byte, and the bench checks that the following write completes normally.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
   localparam int BYTE_W = 8;
   localparam int DEV_W  = 7;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_DEVADR,
      PH_REGADR,
      PH_DATA,
      PH_SKIP
   } cfgw_phase_e;
endpackage

// File: rtl/cfgw_line_sync.sv
module cfgw_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic bus_start,
   output logic bus_stop
);
   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_q;
   logic              sda_q;
   logic              scl_s;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cfgw_line_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_q    <= scl_pipe[STAGES-1];
         sda_q    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_s     = scl_pipe[STAGES-1];
   assign sda_s     = sda_pipe[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
   assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/cfgw_protocol.sv
module cfgw_protocol
   import cfgw_pkg::*;
#(
   parameter int NUM_REGS = 8,
   parameter int IDX_W    = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sda_s,
   input  logic               scl_rise,
   input  logic               scl_fall,
   input  logic               bus_start,
   input  logic               bus_stop,
   input  logic [DEV_W-1:0]   dev_addr,
   output logic               sda_oe,
   output logic               data_commit,
   output logic               wr_en,
   output logic [IDX_W-1:0]   wr_idx,
   output logic [BYTE_W-1:0]  wr_data,
   output logic [BYTE_W-1:0]  ptr
);
   localparam logic [BYTE_W:0] LIMIT = (BYTE_W+1)'(NUM_REGS);

   cfgw_phase_e       phase;
   logic [3:0]        cnt;
   logic              ack_ph;
   logic [BYTE_W-1:0] shreg;
   logic              byte_done;
   logic              addr_hit;

   assign byte_done   = scl_fall && (cnt == 4'd8) && !ack_ph && !bus_start && !bus_stop;
   assign addr_hit    = (shreg[BYTE_W-1:1] == dev_addr) && !shreg[0];
   assign data_commit = byte_done && (phase == PH_DATA);
   assign wr_en       = data_commit && ({1'b0, ptr} < LIMIT);
   assign wr_idx      = ptr[IDX_W-1:0];
   assign wr_data     = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         cnt    <= '0;
         ack_ph <= 1'b0;
         sda_oe <= 1'b0;
         shreg  <= '0;
         ptr    <= '0;
      end else if (bus_start) begin
         phase  <= PH_DEVADR;
         cnt    <= '0;
         ack_ph <= 1'b0;
         sda_oe <= 1'b0;
      end else if (bus_stop) begin
         phase  <= PH_IDLE;
         cnt    <= '0;
         ack_ph <= 1'b0;
         sda_oe <= 1'b0;
      end else if (phase != PH_IDLE && phase != PH_SKIP) begin
         if (scl_rise && cnt < 4'd8) begin
            shreg <= {shreg[BYTE_W-2:0], sda_s};
            cnt   <= cnt + 4'd1;
         end else if (byte_done) begin
            ack_ph <= 1'b1;
            unique case (phase)
               PH_DEVADR: begin
                  if (addr_hit) begin
                     sda_oe <= 1'b1;
                     phase  <= PH_REGADR;
                  end else begin
                     phase  <= PH_SKIP;
                  end
               end
               PH_REGADR: begin
                  ptr    <= shreg;
                  sda_oe <= 1'b1;
                  phase  <= PH_DATA;
               end
               PH_DATA: begin
                  ptr    <= ptr + 1'b1;
                  sda_oe <= 1'b1;
               end
               default: phase <= PH_SKIP;
            endcase
         end else if (scl_fall && ack_ph) begin
            ack_ph <= 1'b0;
            sda_oe <= 1'b0;
            cnt    <= '0;
         end
      end
   end
endmodule

// File: rtl/cfgw_regbank.sv
module cfgw_regbank
   import cfgw_pkg::*;
#(
   parameter int NUM_REGS = 8,
   parameter int IDX_W    = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [IDX_W-1:0]           wr_idx,
   input  logic [BYTE_W-1:0]          wr_data,
   output logic [NUM_REGS*BYTE_W-1:0] regs
);
   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               regs[i*BYTE_W +: BYTE_W] <= '0;
            else if (wr_en && wr_idx == IDX_W'(i))
               regs[i*BYTE_W +: BYTE_W] <= wr_data;
         end
      end
   endgenerate
endmodule

// File: rtl/cfgw_wr_slave.sv
module cfgw_wr_slave
   import cfgw_pkg::*;
#(
   parameter int NUM_REGS    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       scl_i,
   input  logic                       sda_i,
   input  logic [6:0]                 dev_addr_i,
   output logic                       sda_oe_o,
   output logic [NUM_REGS*8-1:0]      regs_o
);
   localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   generate
      if (NUM_REGS < 1 || NUM_REGS > 256) begin : g_bad_depth
         $error("cfgw_wr_slave: NUM_REGS must lie in 1..256");
      end
   endgenerate

   logic              sda_s;
   logic              scl_rise;
   logic              scl_fall;
   logic              bus_start;
   logic              bus_stop;
   logic              data_commit;
   logic              wr_en;
   logic [IDX_W-1:0]  wr_idx;
   logic [BYTE_W-1:0] wr_data;
   logic [BYTE_W-1:0] ptr;

   cfgw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .bus_start (bus_start),
      .bus_stop  (bus_stop)
   );

   cfgw_protocol #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_proto (
      .clk         (clk),
      .rst_n       (rst_n),
      .sda_s       (sda_s),
      .scl_rise    (scl_rise),
      .scl_fall    (scl_fall),
      .bus_start   (bus_start),
      .bus_stop    (bus_stop),
      .dev_addr    (dev_addr_i),
      .sda_oe      (sda_oe_o),
      .data_commit (data_commit),
      .wr_en       (wr_en),
      .wr_idx      (wr_idx),
      .wr_data     (wr_data),
      .ptr         (ptr)
   );

   cfgw_regbank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .regs    (regs_o)
   );
endmodule

// File: rtl/cfgw_checker.sv
module cfgw_checker #(
   parameter int NUM_REGS = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  sda_oe_o,
   input logic [NUM_REGS*8-1:0] regs_o,
   input logic                  scl_fall,
   input logic                  bus_start,
   input logic                  bus_stop,
   input logic                  data_commit,
   input logic                  wr_en,
   input logic [7:0]            ptr
);
   AST_OE_RISE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> $past(scl_fall)); // R10
   AST_OE_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_oe_o) |-> ($past(scl_fall) || $past(bus_start) || $past(bus_stop))); // R10
   AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stop |=> !sda_oe_o); // R8
   AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      bus_start |=> !sda_oe_o); // R9
   AST_COMMIT_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
      data_commit |=> sda_oe_o); // R5
   AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(regs_o)); // R7
   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      data_commit |=> (ptr == $past(ptr) + 8'd1)); // R6
endmodule

bind cfgw_wr_slave cfgw_checker #(.NUM_REGS(NUM_REGS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sda_oe_o    (sda_oe_o),
   .regs_o      (regs_o),
   .scl_fall    (scl_fall),
   .bus_start   (bus_start),
   .bus_stop    (bus_stop),
   .data_commit (data_commit),
   .wr_en       (wr_en),
   .ptr         (ptr)
);

// File: tb/cfgw_wr_slave_tb.sv
module cfgw_wr_slave_tb;
   localparam int N = 8;
   localparam int Q = 6;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           host_scl = 1'b1;
   logic           host_sda = 1'b1;
   logic [6:0]     strap = 7'h2A;
   logic           sda_oe;
   logic [N*8-1:0] regs;
   logic           sda_bus;

   int             vectors = 0;
   int             fails = 0;
   bit             done = 1'b0;
   logic [7:0]     model [N];

   assign sda_bus = host_sda & ~sda_oe;

   always #2 clk = ~clk;

   cfgw_wr_slave #(.NUM_REGS(N), .SYNC_STAGES(2)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (host_scl),
      .sda_i      (sda_bus),
      .dev_addr_i (strap),
      .sda_oe_o   (sda_oe),
      .regs_o     (regs)
   );

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      host_sda = 1'b1; wq(Q);
      host_scl = 1'b1; wq(Q);
      host_sda = 1'b0; wq(Q);
      host_scl = 1'b0; wq(Q);
   endtask

   task automatic bus_stop();
      host_sda = 1'b0; wq(Q);
      host_scl = 1'b1; wq(Q);
      host_sda = 1'b1; wq(Q);
   endtask

   task automatic send_bits(input logic [7:0] b, input int nbits);
      for (int i = 7; i > 7 - nbits; i--) begin
         host_sda = b[i]; wq(Q);
         host_scl = 1'b1; wq(2*Q);
         host_scl = 1'b0; wq(Q);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      send_bits(b, 8);
      host_sda = 1'b1; wq(Q);
      host_scl = 1'b1; wq(Q);
      acked = !sda_bus;
      wq(Q);
      host_scl = 1'b0; wq(Q);
   endtask

   task automatic check_regs(input string req);
      for (int k = 0; k < N; k++)
         check(req, int'(regs[k*8 +: 8]), int'(model[k]));
   endtask

   task automatic write_txn(input logic [6:0] a, input bit rw, input logic [7:0] p,
                            input int n, input logic [7:0] seed, input bit exp_ack);
      bit         ak;
      logic [7:0] ptr_m;
      bus_start();
      send_byte({a, rw}, ak);
      check(exp_ack ? "R2 address ack" : "R3 address no-ack", int'(ak), int'(exp_ack));
      send_byte(p, ak);
      check(exp_ack ? "R4 pointer ack" : "R3 pointer ignored", int'(ak), int'(exp_ack));
      ptr_m = p;
      for (int j = 0; j < n; j++) begin
         logic [7:0] d;
         d = seed + 8'(j * 37);
         send_byte(d, ak);
         if (exp_ack) begin
            check(int'(ptr_m) < N ? "R5 data ack" : "R7 out-of-range ack", int'(ak), 1);
            if (int'(ptr_m) < N) model[ptr_m[2:0]] = d;
            ptr_m = ptr_m + 8'd1;
         end else begin
            check("R3 data ignored", int'(ak), 0);
         end
      end
      bus_stop();
      check_regs(exp_ack ? "R6 burst contents" : "R3 regs unchanged");
   endtask

   initial begin
      bit ak;
      logic [6:0] straps [4];
      straps[0] = 7'h00; straps[1] = 7'h2A; straps[2] = 7'h55; straps[3] = 7'h7F;
      for (int k = 0; k < N; k++) model[k] = 8'h00;
      wq(5);
      check("R1 oe idle", int'(sda_oe), 0);
      check_regs("R1 reset zero");
      rst_n = 1'b1;
      wq(5);
      check("R1 oe idle after reset", int'(sda_oe), 0);
      check_regs("R1 regs after reset");

      for (int s = 0; s < 4; s++) begin
         strap = straps[s];
         wq(Q);
         for (int p = 0; p < N; p++)
            write_txn(strap, 1'b0, 8'(p), 3, 8'(s * 64 + p * 11 + 1), 1'b1);
         write_txn(strap ^ 7'h01, 1'b0, 8'd0, 2, 8'hEE, 1'b0);
         write_txn(strap ^ 7'h40, 1'b0, 8'd3, 2, 8'hDD, 1'b0);
         write_txn(strap, 1'b1, 8'd1, 2, 8'hCC, 1'b0);
      end

      // R7 burst running off the end of the bank
      write_txn(strap, 1'b0, 8'd6, 4, 8'h5C, 1'b1);
      // R6 wrap from 255 to 0; the third byte lands in register 0
      write_txn(strap, 1'b0, 8'd254, 3, 8'h71, 1'b1);
      check("R6 wrap lands in reg0", int'(regs[7:0]), int'(8'h71 + 8'(2 * 37)));

      // R8 bytes after STOP without a new START
      send_byte({strap, 1'b0}, ak);
      check("R8 no ack after stop", int'(ak), 0);
      send_byte(8'h02, ak);
      check("R8 no ack after stop", int'(ak), 0);
      bus_stop();
      check_regs("R8 regs unchanged");

      // R9 repeated START part-way through the pointer byte, then a full write
      bus_start();
      send_byte({strap, 1'b0}, ak);
      check("R9 address ack", int'(ak), 1);
      send_bits(8'hFF, 3);
      bus_start();
      send_byte({strap, 1'b0}, ak);
      check("R9 restart address ack", int'(ak), 1);
      send_byte(8'h04, ak);
      check("R9 pointer ack", int'(ak), 1);
      send_byte(8'hA5, ak);
      check("R9 data ack", int'(ak), 1);
      model[4] = 8'hA5;
      bus_stop();
      check_regs("R9 write after restart");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule